// File: doc/BRIEF.md
# Display transmitter control and status register bank

This block is the byte-wide register file that sits behind the register read/write port of a two-wire serial slave in a display link transmitter. It returns fixed identification and operating-frequency bytes. It holds the writable mode bits that steer the datapath: driver power, input latch edge, input bus width, input clock type, and the two sync enables. It also gates the incoming horizontal and vertical sync lines according to those enables.

A sticky, active-low monitor interrupt watches one of two detect inputs (receiver sense or hot plug), chosen by a control bit. Both inputs are resynchronised into the register clock domain. Any level change on the watched input clears the flag to 0. Writing a one to the flag bit sets it back to 1. A 3-bit selector routes the flag, one of the raw detect levels, or a constant high level to a status output pin. The low-swing indication arrives as a plain input bit and is only reported.

Top module: `dtx_csr_bank`

## Requirements
- R1: Reads return fixed bytes at these addresses: 0x00=05h, 0x01=13h, 0x02=24h, 0x03=67h, 0x04=00h, 0x05=19h (low frequency limit), 0x06=55h (high frequency limit). Every address other than 0x00-0x06, 0x08 and 0x09 reads 00h. Writes to any address other than 0x08 and 0x09 change no readback and no output.
- R2: After reset, the mode register (0x08) reads 3Bh and the control register (0x09) reads 05h, plus the low-swing input in bit 7 and the synchronised detect levels in bits 5 and 6.
- R3: Mode register 0x08 has this layout: bit0 driver power (1 = on), bit1 falling-edge latch, bit2 dual bus, bit3 single-ended clock, bit4 HSYNC enable, bit5 VSYNC enable. Bits 7:6 read 0. A write stores bits 5:0. `edge_fall_o`, `bus_dual_o` and `clk_single_o` equal bits 1, 2 and 3.
- R4: `drv_oe_o` equals the driver-power bit. While that bit is 0, the registers can still be read and written.
- R5: `hsync_o` equals `hsync_i` when the HSYNC enable bit is 1 and is 0 otherwise. `vsync_o` is gated the same way by the VSYNC enable bit.
- R6: The interrupt flag (bit0 of 0x09, active low) drops to 0 when the watched detect input changes level, in either direction. With the default two synchroniser stages, an input change set up before clock edge k shows in the flag after edge k+2.
- R7: Writing 0x09 with bit0 = 1 sets the flag to 1. Writing bit0 = 0 leaves it unchanged. The flag stays at 0 until it is cleared.
- R8: Bit1 of 0x09 picks the watched input: 0 = receiver sense, 1 = hot plug. Changes on the unwatched input do not affect the flag.
- R9: If a change event and a clearing write fall in the same cycle, the flag ends at 0.
- R10: Bits 4:2 of 0x09 select what drives `status_pin_o`: 000 = 1, 001 = flag, 010 = synchronised receiver sense, 011 = synchronised hot plug, 1xx = 1.
- R11: Bits 5 and 6 of 0x09 read the synchronised receiver-sense and hot-plug levels. Bit 7 reads `low_swing_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address from the serial slave |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| det_rsense_i | input | 1 | Receiver-sense detect input (asynchronous) |
| det_hotplug_i | input | 1 | Hot-plug detect input (asynchronous) |
| low_swing_i | input | 1 | Low-swing input indication |
| hsync_i | input | 1 | Horizontal sync in |
| vsync_i | input | 1 | Vertical sync in |
| hsync_o | output | 1 | Gated horizontal sync |
| vsync_o | output | 1 | Gated vertical sync |
| drv_oe_o | output | 1 | Line driver output enable |
| edge_fall_o | output | 1 | Falling-edge latch select |
| bus_dual_o | output | 1 | Dual input bus select |
| clk_single_o | output | 1 | Single-ended input clock select |
| status_pin_o | output | 1 | Selectable status output |

## Verification
The assertions check the interrupt flag on every cycle. A change event forces it low on the next cycle, it holds low until a clear, a clear without a change sets it high, and a collision keeps it low. They also check that the mode register changes only on a write to its own address and that the status pin tracks the flag when the flag is selected. Only the bench scenarios can show the end-to-end behaviour. This covers the synchroniser latency, the watched-versus-unwatched input choice, both edge directions, the full 64-value mode sweep with sync gating, every selector code, and the ignored writes to read-only space.

// File: rtl/dtx_csr_pkg.sv
package dtx_csr_pkg;

   localparam int unsigned REG_W = 8;

   // register addresses
   localparam int unsigned ADR_VEN_LO  = 'h00;
   localparam int unsigned ADR_VEN_HI  = 'h01;
   localparam int unsigned ADR_DEV_LO  = 'h02;
   localparam int unsigned ADR_DEV_HI  = 'h03;
   localparam int unsigned ADR_REV     = 'h04;
   localparam int unsigned ADR_FRQ_LO  = 'h05;
   localparam int unsigned ADR_FRQ_HI  = 'h06;
   localparam int unsigned ADR_MODE    = 'h08;
   localparam int unsigned ADR_CTL     = 'h09;

   // status pin selector codes
   localparam logic [2:0] SEL_FORCE  = 3'b000;
   localparam logic [2:0] SEL_FLAG   = 3'b001;
   localparam logic [2:0] SEL_RSENSE = 3'b010;
   localparam logic [2:0] SEL_HPLUG  = 3'b011;

   typedef struct packed {
      logic vs_en;
      logic hs_en;
      logic clk_single;
      logic bus_dual;
      logic edge_fall;
      logic pwr_on;
   } mode_t;

   localparam mode_t MODE_RESET = '{vs_en: 1'b1, hs_en: 1'b1, clk_single: 1'b1,
                                    bus_dual: 1'b0, edge_fall: 1'b1, pwr_on: 1'b1};

   typedef struct packed {
      logic [2:0] pin_sel;
      logic       src_hplug;
   } ctl_t;

   localparam ctl_t CTL_RESET = '{pin_sel: SEL_FLAG, src_hplug: 1'b0};

endpackage

// File: rtl/dtx_sync.sv
module dtx_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dtx_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("dtx_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= async_i;
         for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dtx_irq_monitor.sv
module dtx_irq_monitor (
   input  logic clk,
   input  logic rst_n,
   input  logic rsense_s,
   input  logic hplug_s,
   input  logic src_hplug,
   input  logic clr_req,
   output logic flag_n
);

   logic rsense_d, hplug_d;
   logic rsense_chg, hplug_chg, evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsense_d <= 1'b0;
         hplug_d  <= 1'b0;
      end else begin
         rsense_d <= rsense_s;
         hplug_d  <= hplug_s;
      end
   end

   // per-input edges, so switching the source creates no event
   assign rsense_chg = rsense_s ^ rsense_d;
   assign hplug_chg  = hplug_s ^ hplug_d;
   assign evt        = src_hplug ? hplug_chg : rsense_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_n <= 1'b1;
      else if (evt)     flag_n <= 1'b0;   // change beats a same-cycle clear
      else if (clr_req) flag_n <= 1'b1;
   end

   p_flag_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !flag_n);

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_n && !clr_req) |=> !flag_n);

   p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !evt) |=> flag_n);

   p_collision_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && evt) |=> !flag_n);

   p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_n && !evt) |=> flag_n);

endmodule

// File: rtl/dtx_status_mux.sv
module dtx_status_mux (
   input  logic [2:0] sel,
   input  logic       flag_n,
   input  logic       rsense_s,
   input  logic       hplug_s,
   output logic       pin_o
);
   import dtx_csr_pkg::*;

   always_comb begin
      unique case (sel)
         SEL_FORCE:  pin_o = 1'b1;
         SEL_FLAG:   pin_o = flag_n;
         SEL_RSENSE: pin_o = rsense_s;
         SEL_HPLUG:  pin_o = hplug_s;
         default:    pin_o = 1'b1;   // reserved codes
      endcase
   end

endmodule

// File: rtl/dtx_csr_bank.sv
module dtx_csr_bank #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [15:0] VENDOR_ID   = 16'h1305,
   parameter logic [15:0] DEVICE_ID   = 16'h6724,
   parameter logic [7:0]  REVISION    = 8'h00,
   parameter logic [7:0]  FREQ_LO     = 8'h19,
   parameter logic [7:0]  FREQ_HI     = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              det_rsense_i,
   input  logic              det_hotplug_i,
   input  logic              low_swing_i,
   input  logic              hsync_i,
   input  logic              vsync_i,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              drv_oe_o,
   output logic              edge_fall_o,
   output logic              bus_dual_o,
   output logic              clk_single_o,
   output logic              status_pin_o
);
   import dtx_csr_pkg::*;

   localparam int unsigned MODE_W = $bits(mode_t);

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("dtx_csr_bank: ADDR_W must be at least 4");
      end
      if (MODE_W > REG_W) begin : g_bad_mode
         $error("dtx_csr_bank: mode fields exceed register width");
      end
   endgenerate

   mode_t mode_q;
   ctl_t  ctl_q;
   logic  rsense_s, hplug_s, flag_n;
   logic  wr_mode, wr_ctl, clr_req;
   logic  [1:0] det_sync;
   logic  unused_wdata;

   assign wr_mode = reg_wr && (reg_addr == ADDR_W'(ADR_MODE));
   assign wr_ctl  = reg_wr && (reg_addr == ADDR_W'(ADR_CTL));
   assign clr_req = wr_ctl && reg_wdata[0];
   assign unused_wdata = ^reg_wdata[7:6];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         ctl_q  <= CTL_RESET;
      end else begin
         if (wr_mode) mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
         if (wr_ctl)  ctl_q  <= '{pin_sel: reg_wdata[4:2], src_hplug: reg_wdata[1]};
      end
   end

   dtx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({det_hotplug_i, det_rsense_i}),
      .sync_o  (det_sync)
   );
   assign rsense_s = det_sync[0];
   assign hplug_s  = det_sync[1];

   dtx_irq_monitor u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .rsense_s  (rsense_s),
      .hplug_s   (hplug_s),
      .src_hplug (ctl_q.src_hplug),
      .clr_req   (clr_req),
      .flag_n    (flag_n)
   );

   dtx_status_mux u_pin (
      .sel      (ctl_q.pin_sel),
      .flag_n   (flag_n),
      .rsense_s (rsense_s),
      .hplug_s  (hplug_s),
      .pin_o    (status_pin_o)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(ADR_VEN_LO): reg_rdata = VENDOR_ID[7:0];
         ADDR_W'(ADR_VEN_HI): reg_rdata = VENDOR_ID[15:8];
         ADDR_W'(ADR_DEV_LO): reg_rdata = DEVICE_ID[7:0];
         ADDR_W'(ADR_DEV_HI): reg_rdata = DEVICE_ID[15:8];
         ADDR_W'(ADR_REV):    reg_rdata = REVISION;
         ADDR_W'(ADR_FRQ_LO): reg_rdata = FREQ_LO;
         ADDR_W'(ADR_FRQ_HI): reg_rdata = FREQ_HI;
         ADDR_W'(ADR_MODE):   reg_rdata = REG_W'(mode_q);
         ADDR_W'(ADR_CTL):    reg_rdata = {low_swing_i, hplug_s, rsense_s,
                                           ctl_q.pin_sel, ctl_q.src_hplug, flag_n};
         default:             reg_rdata = '0;
      endcase
   end

   assign hsync_o      = hsync_i & mode_q.hs_en;
   assign vsync_o      = vsync_i & mode_q.vs_en;
   assign drv_oe_o     = mode_q.pwr_on;
   assign edge_fall_o  = mode_q.edge_fall;
   assign bus_dual_o   = mode_q.bus_dual;
   assign clk_single_o = mode_q.clk_single;

   p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mode |=> $stable(mode_q));

   p_ctl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctl |=> $stable(ctl_q));

   p_pin_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q.pin_sel == SEL_FLAG) |-> (status_pin_o == flag_n));

endmodule

// File: tb/dtx_csr_bank_tb.sv
module dtx_csr_bank_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic       reg_wr;
   logic       rs, hp, lsw, hs_in, vs_in;
   logic       hs_out, vs_out, oe, edg, dual, csing, pin;
   int         n_chk = 0, n_err = 0;

   always #2 clk = ~clk;

   dtx_csr_bank u_dut (
      .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr (reg_wr),
      .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .det_rsense_i (rs), .det_hotplug_i (hp), .low_swing_i (lsw),
      .hsync_i (hs_in), .vsync_i (vs_in), .hsync_o (hs_out), .vsync_o (vs_out),
      .drv_oe_o (oe), .edge_fall_o (edg), .bus_dual_o (dual),
      .clk_single_o (csing), .status_pin_o (pin)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic int id_byte(input int a);
      case (a)
         0: return 'h05; 1: return 'h13; 2: return 'h24; 3: return 'h67;
         4: return 'h00; 5: return 'h19; 6: return 'h55;
         default: return 0;
      endcase
   endfunction

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // change a detect input, wait until the flag has had time to react
   task automatic det_set(input bit which_hp, input logic v);
      @(negedge clk);
      if (which_hp) hp = v; else rs = v;
      repeat (3) @(negedge clk);
      #1;
   endtask

   function automatic int pin_exp(input int sel, input int f, input int r, input int h);
      case (sel)
         0: return 1; 1: return f; 2: return r; 3: return h;
         default: return 1;
      endcase
   endfunction

   initial begin
      #(4 * 150000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [7:0] d;
      rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0;
      rs = 0; hp = 0; lsw = 1; hs_in = 0; vs_in = 0;
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;

      // R2 reset state
      rd(8'h08, d); check("R2 mode reset", d, 'h3B);
      rd(8'h09, d); check("R2 ctl reset", d, 'h85);
      check("R4 oe reset", oe, 1);
      check("R3 edge reset", edg, 1);
      check("R3 dual reset", dual, 0);
      check("R3 clk reset", csing, 1);
      check("R10 pin reset", pin, 1);

      // R1 address sweep of fixed space
      for (int a = 0; a < 256; a++) begin
         if (a != 8 && a != 9) begin
            rd(a[7:0], d); check("R1 read", d, id_byte(a));
         end
      end
      // R1 writes to read-only and unmapped space ignored
      for (int a = 0; a < 256; a++) begin
         if (a != 8 && a != 9) wr(a[7:0], 8'hFF);
      end
      for (int a = 0; a < 256; a++) begin
         if (a != 8 && a != 9) begin
            rd(a[7:0], d); check("R1 after write", d, id_byte(a));
         end
      end
      rd(8'h08, d); check("R1 mode untouched", d, 'h3B);
      rd(8'h09, d); check("R1 ctl untouched", d, 'h85);

      // R11 low-swing reporting
      lsw = 0; rd(8'h09, d); check("R11 low swing 0", d[7], 0);
      lsw = 1;

      // R3 R4 R5 full mode sweep
      for (int v = 0; v < 64; v++) begin
         wr(8'h08, 8'(v | 'hC0));
         rd(8'h08, d); check("R3 readback", d, v);
         check("R4 oe", oe, v & 1);
         check("R3 edge", edg, (v >> 1) & 1);
         check("R3 dual", dual, (v >> 2) & 1);
         check("R3 clk", csing, (v >> 3) & 1);
         for (int s = 0; s < 4; s++) begin
            hs_in = s[0]; vs_in = s[1]; #1;
            check("R5 hsync", hs_out, s & (v >> 4) & 1);
            check("R5 vsync", vs_out, (s >> 1) & (v >> 5) & 1);
         end
      end
      wr(8'h08, 8'h3B);

      // R8 unwatched hot plug change with source = receiver sense
      det_set(1, 1);
      rd(8'h09, d); check("R8 unwatched hp", d[0], 1);
      // R6 rising receiver sense
      det_set(0, 1);
      rd(8'h09, d); check("R6 rise", d[0], 0);
      check("R10 pin follows flag", pin, 0);
      check("R11 rsense bit", d[5], 1);
      check("R11 hplug bit", d[6], 1);
      // R7 write zero keeps flag
      wr(8'h09, 8'h04);
      repeat (5) @(negedge clk);
      rd(8'h09, d); check("R7 sticky", d[0], 0);
      wr(8'h09, 8'h05);
      rd(8'h09, d); check("R7 clear", d[0], 1);
      // R6 falling receiver sense
      det_set(0, 0);
      rd(8'h09, d); check("R6 fall", d[0], 0);
      wr(8'h09, 8'h05);

      // R8 source = hot plug
      wr(8'h09, 8'h07);
      rd(8'h09, d); check("R8 cleared", d[0], 1);
      det_set(0, 1);
      rd(8'h09, d); check("R8 unwatched rs", d[0], 1);
      det_set(1, 0);
      rd(8'h09, d); check("R8 watched hp", d[0], 0);
      wr(8'h09, 8'h07);
      rd(8'h09, d); check("R7 clear hp", d[0], 1);

      // R9 collision: event and clear in the same cycle
      @(negedge clk); hp = 1;
      repeat (2) @(negedge clk);
      reg_addr = 8'h09; reg_wdata = 8'h07; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
      rd(8'h09, d); check("R9 collision", d[0], 0);
      wr(8'h09, 8'h07);
      rd(8'h09, d); check("R9 later clear", d[0], 1);

      // R10 selector sweep: rs=1 hp=1 flag=1
      for (int s = 0; s < 8; s++) begin
         wr(8'h09, 8'((s << 2) | 2));
         #1; check("R10 sel A", pin, pin_exp(s, 1, 1, 1));
      end
      det_set(1, 0);   // flag 0, hp 0
      det_set(0, 0);   // unwatched, rs 0
      for (int s = 0; s < 8; s++) begin
         wr(8'h09, 8'((s << 2) | 2));
         #1; check("R10 sel B", pin, pin_exp(s, 0, 0, 0));
      end
      det_set(0, 1);   // rs 1, flag stays 0
      for (int s = 0; s < 8; s++) begin
         wr(8'h09, 8'((s << 2) | 2));
         #1; check("R10 sel C", pin, pin_exp(s, 0, 1, 0));
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule